// File: doc/BRIEF.md
# Byte-Serial Descriptor CRC32 Engine

This block computes a 32-bit cyclic redundancy check over a stream of bytes, one byte per clock. Command descriptor blocks are protected with this checksum. The generator polynomial is 0x20044009 (x^32 + x^29 + x^18 + x^14 + x^3 + 1) in normal form. Bits are processed most significant first. There is no reflection of input or output and no final inversion. The value left in the register after the last byte is the checksum.

The producer presents bytes with a valid/ready handshake. A start flag on a byte loads the seed and folds that byte in during the same cycle. A last flag closes the buffer. The seed is either the default all-ones value or a caller-supplied value. A caller can therefore chain buffers by feeding one buffer's result in as the seed of the next. One cycle after the last byte is taken, a one-cycle done pulse appears. The result then stays on the output until the next start.

Top module: `crc32_byte_engine`

## Requirements
- R1: While rst_n is low at a clock edge, crc_out becomes 0xFFFFFFFF and done and in_ready become 0. in_ready is 1 from the first clock edge taken with rst_n high.
- R2: A byte d folds into register c as c' = (c << 8) ^ T[(c >> 24) ^ d]. T[i] is built by placing i in bits 31:24 and doing eight steps, each a left shift that is XORed with 0x20044009 when bit 31 was set before the shift. Bytes 0x01, 0x02, 0x03, 0x04 with seed 0xFFFFFFFF give 0xF33CB7D3.
- R3: A byte accepted with in_start=1 and seed_use=0 is folded into 0xFFFFFFFF in that same cycle. Any earlier register value is discarded.
- R4: A byte accepted with in_start=1 and seed_use=1 is folded into seed_value. Seeding buffer B with the result of buffer A gives the checksum of A followed by B.
- R5: Bytes accepted on consecutive cycles are each folded in, at one byte per clock with no stall.
- R6: On a cycle without an accepted byte, crc_out keeps its value.
- R7: done is 1 for exactly the cycle after a folded byte carrying in_last, and 0 otherwise.
- R8: After a buffer closes, bytes accepted without in_start are consumed but leave crc_out unchanged and raise no done.
- R9: A byte carrying both in_start and in_last forms a one-byte buffer whose result appears together with done on the next cycle.
- R10: in_start or in_last with in_valid low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on in_data is offered |
| in_ready | output | 1 | Engine takes a byte this cycle |
| in_data | input | 8 | Data byte |
| in_start | input | 1 | Byte opens a new buffer and loads the seed |
| in_last | input | 1 | Byte closes the buffer |
| seed_use | input | 1 | Use seed_value instead of 0xFFFFFFFF on start |
| seed_value | input | 32 | Caller seed for chaining |
| crc_out | output | 32 | Running / final checksum |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions assume two things about the producer. First, in_start, in_last and in_data matter only while in_valid is high. Second, a byte that opens a buffer carries in_start. The done check is tied to bytes that carry in_start, so it does not depend on whether a buffer is already open. The random stimulus builds buffers of random length, inserts random idle gaps, and sometimes raises in_start or in_last with in_valid low. It also sends stray bytes between buffers. A bench model that follows the open/closed rule of R8 predicts every cycle, so input the design ignores is still checked at crc_out and done.

// File: rtl/crc_eng_pkg.sv
// Package: shared widths and constants for the byte-serial CRC engine.
// Assumes a single normal-form (non-reflected) polynomial per instance.
package crc_eng_pkg;
    localparam int          CRC_W        = 32;
    localparam int          BYTE_W       = 8;
    localparam logic [31:0] POLY_DEFAULT = 32'h2004_4009;
    localparam logic [31:0] SEED_DEFAULT = 32'hFFFF_FFFF;
endpackage

// File: rtl/crc_seed_sel.sv
// Module: crc_seed_sel
// Picks the register value a byte is folded into. On a start byte this is
// the default seed or the caller seed; otherwise it is the running value.
// Assumes start is only meaningful for a byte that is being accepted.
module crc_seed_sel #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    INIT = '1
) (
    input  logic         start,
    input  logic         use_seed,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] running,
    output logic [W-1:0] base
);
    // Select the fold base for the current byte.
    always_comb begin
        if (!start)
            base = running;
        else if (use_seed)
            base = seed;
        else
            base = INIT;
    end
endmodule

// File: rtl/crc_fold.sv
// Module: crc_fold
// Combinational fold of one DW-bit word into a W-bit CRC, MSB first. It is
// built as a chain of DW single-bit LFSR steps, equivalent to a table lookup
// on (crc >> (W-DW)) ^ data. Assumes DW <= W.
module crc_fold #(
    parameter int           W    = 32,
    parameter int           DW   = 8,
    parameter logic [W-1:0] POLY = 32'h2004_4009
) (
    input  logic [W-1:0]  crc_in,
    input  logic [DW-1:0] data,
    output logic [W-1:0]  crc_o
);
    logic [W-1:0] stage [0:DW];

    assign stage[0] = crc_in;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        logic fb;
        // One shift step: feedback is the top bit XOR the next data bit.
        assign fb           = stage[g][W-1] ^ data[DW-1-g];
        assign stage[g+1]   = {stage[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = stage[DW];
endmodule

// File: rtl/crc32_byte_engine.sv
// Module: crc32_byte_engine (top)
// Byte-serial CRC over descriptor buffers. It accepts one byte per clock
// once out of reset. A start byte loads the seed and folds at once; a last
// byte closes the buffer and produces a done pulse the next cycle. Bytes
// arriving while no buffer is open are consumed and dropped.
// Assumes in_start/in_last are qualified by in_valid.
module crc32_byte_engine
    import crc_eng_pkg::*;
#(
    parameter int                 CRC_WIDTH  = CRC_W,
    parameter int                 DATA_WIDTH = BYTE_W,
    parameter logic [CRC_W-1:0]   POLY       = POLY_DEFAULT,
    parameter logic [CRC_W-1:0]   INIT       = SEED_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_WIDTH-1:0] in_data,
    input  logic                  in_start,
    input  logic                  in_last,
    input  logic                  seed_use,
    input  logic [CRC_WIDTH-1:0]  seed_value,
    output logic [CRC_WIDTH-1:0]  crc_out,
    output logic                  done
);
    localparam logic [CRC_WIDTH-1:0] POLY_W = POLY[CRC_WIDTH-1:0];
    localparam logic [CRC_WIDTH-1:0] INIT_W = INIT[CRC_WIDTH-1:0];

    logic                 ready_q;
    logic                 open_q;
    logic                 done_q;
    logic [CRC_WIDTH-1:0] crc_q;
    logic [CRC_WIDTH-1:0] fold_base;
    logic [CRC_WIDTH-1:0] fold_next;
    logic                 take;
    logic                 fold_en;

    // Handshake and fold qualification.
    assign take    = in_valid & ready_q;
    assign fold_en = take & (in_start | open_q);

    crc_seed_sel #(.W(CRC_WIDTH), .INIT(INIT_W)) u_seed (
        .start    (in_start),
        .use_seed (seed_use),
        .seed     (seed_value),
        .running  (crc_q),
        .base     (fold_base)
    );

    crc_fold #(.W(CRC_WIDTH), .DW(DATA_WIDTH), .POLY(POLY_W)) u_fold (
        .crc_in (fold_base),
        .data   (in_data),
        .crc_o  (fold_next)
    );

    // State update: ready, buffer-open flag, CRC register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            open_q  <= 1'b0;
            done_q  <= 1'b0;
            crc_q   <= INIT_W;
        end else begin
            ready_q <= 1'b1;
            done_q  <= fold_en & in_last;
            if (fold_en) begin
                crc_q  <= fold_next;
                open_q <= ~in_last;
            end
        end
    end

    assign in_ready = ready_q;
    assign crc_out  = crc_q;
    assign done     = done_q;
endmodule

// File: rtl/crc32_byte_engine_chk.sv
// Module: crc32_byte_engine_chk
// Port-level properties of the CRC engine, bound to every instance.
// Assumes in_start marks each byte that opens a buffer.
module crc32_byte_engine_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_start,
    input logic          in_last,
    input logic [CW-1:0] crc_out,
    input logic          done
);
    // R1: ready follows a cycle out of reset.
    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

    // R9 / R7: a start+last byte that is taken yields done next cycle.
    a_r9_single_byte_done: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_start && in_last) |=> done);

    // R7: no done without a last byte being taken the cycle before.
    a_r7_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready && in_last) |=> !done);

    // R6: CRC holds when no byte is taken.
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(crc_out));
endmodule

bind crc32_byte_engine crc32_byte_engine_chk #(.CW(CRC_WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_start (in_start),
    .in_last  (in_last),
    .crc_out  (crc_out),
    .done     (done)
);

// File: tb/tb_crc32_byte_engine.sv
module tb_crc32_byte_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_start = 1'b0;
    logic        in_last = 1'b0;
    logic        seed_use = 1'b0;
    logic [31:0] seed_value = '0;
    logic [31:0] crc_out;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] exp_crc = 32'hFFFF_FFFF;
    logic        exp_done = 1'b0;
    logic        exp_open = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc32_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_start(in_start), .in_last(in_last),
        .seed_use(seed_use), .seed_value(seed_value),
        .crc_out(crc_out), .done(done)
    );

    // Reference: table entry for index i, built by eight conditional shifts.
    function automatic logic [31:0] tab_entry(input logic [7:0] i);
        logic [31:0] t = {i, 24'h0};
        for (int k = 0; k < 8; k++)
            t = t[31] ? ((t << 1) ^ 32'h2004_4009) : (t << 1);
        return t;
    endfunction

    function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [7:0] b);
        return (c << 8) ^ tab_entry(c[31:24] ^ b);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the model, then compare after the edge.
    task automatic step(input logic v, input logic s, input logic l, input logic [7:0] b,
                        input logic u, input logic [31:0] sd, input string tag);
        in_valid = v; in_start = s; in_last = l; in_data = b;
        seed_use = u; seed_value = sd;
        @(negedge clk);
        exp_done = 1'b0;
        if (v) begin
            if (s) begin
                exp_crc  = ref_fold(u ? sd : 32'hFFFF_FFFF, b);
                exp_open = !l;
                exp_done = l;
            end else if (exp_open) begin
                exp_crc  = ref_fold(exp_crc, b);
                exp_open = !l;
                exp_done = l;
            end
        end
        check(crc_out == exp_crc, {tag, " crc"}, crc_out, exp_crc);
        check(done == exp_done, {tag, " done"}, {31'd0, done}, {31'd0, exp_done});
    endtask

    initial begin
        logic [31:0] chain;
        void'($urandom(32'd20240611));
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(crc_out == 32'hFFFF_FFFF, "R1 crc in reset", crc_out, 32'hFFFF_FFFF);
        check(done == 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
        check(in_ready == 1'b0, "R1 ready in reset", {31'd0, in_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", {31'd0, in_ready}, 32'd1);

        // R2 / R5: reference vector, back to back.
        step(1, 1, 0, 8'h01, 0, 0, "R2");
        step(1, 0, 0, 8'h02, 0, 0, "R5");
        step(1, 0, 0, 8'h03, 0, 0, "R5");
        step(1, 0, 1, 8'h04, 0, 0, "R2");
        check(crc_out == 32'hF33C_B7D3, "R2 vector", crc_out, 32'hF33C_B7D3);
        check(done == 1'b1, "R7 done pulse", {31'd0, done}, 32'd1);
        step(0, 0, 0, 8'h00, 0, 0, "R7 pulse ends");

        // R8: stray bytes after close are dropped.
        step(1, 0, 0, 8'hA5, 0, 0, "R8");
        step(1, 0, 1, 8'h5A, 0, 0, "R8");
        check(crc_out == 32'hF33C_B7D3, "R8 held", crc_out, 32'hF33C_B7D3);

        // R10: start/last without valid.
        step(0, 1, 1, 8'h77, 0, 0, "R10");

        // R4: chaining A={01,02} then B={03,04} seeded with A's result.
        step(1, 1, 0, 8'h01, 0, 0, "R4");
        step(1, 0, 1, 8'h02, 0, 0, "R4");
        chain = crc_out;
        step(1, 1, 0, 8'h03, 1, chain, "R4");
        step(1, 0, 1, 8'h04, 1, 32'h1234_5678, "R4");
        check(crc_out == 32'hF33C_B7D3, "R4 chained", crc_out, 32'hF33C_B7D3);

        // R9: one-byte buffer; R3: start mid-buffer discards old value.
        step(1, 1, 1, 8'hC3, 0, 0, "R9");
        step(1, 1, 0, 8'h10, 0, 0, "R3");
        step(1, 1, 1, 8'h20, 0, 0, "R3");
        check(crc_out == ref_fold(32'hFFFF_FFFF, 8'h20), "R3 restart",
              crc_out, ref_fold(32'hFFFF_FFFF, 8'h20));

        // Random buffers with gaps, seeds and stray control.
        for (int f = 0; f < 300; f++) begin
            int len = 1 + int'($urandom_range(0, 11));
            logic u = 1'($urandom_range(0, 1));
            logic [31:0] sd = $urandom();
            for (int k = 0; k < len; k++) begin
                while ($urandom_range(0, 3) == 0)
                    step(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                         8'($urandom()), u, sd, "R6");
                step(1, k == 0, k == len - 1, 8'($urandom()), u, sd, "R2");
            end
            if ($urandom_range(0, 4) == 0)
                step(1, 0, 1'($urandom_range(0, 1)), 8'($urandom()), 0, 0, "R8");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule